// File: doc/BRIEF.md
# Parameterized Floating-Point Adder/Subtractor

This block adds or subtracts two packed floating-point operands whose layout is set by parameters: one sign bit, `EXP_W` exponent bits and `MAN_W` stored fraction bits. One netlist serves a 16-bit brain-float layout (8,7), a 24-bit layout (8,15) and 32-bit single precision (8,23). A select input picks addition or subtraction. For subtraction the sign of the second operand is inverted, so both operations run on one datapath.

Each operand is split into sign, exponent and significand. The implicit leading one is restored for every nonzero exponent. The operand with the smaller magnitude is shifted right by the exponent gap into a datapath of double significand width plus a carry bit. The magnitudes are then added or subtracted without sign. A leading-zero count normalizes the sum: a carry moves it right by one, a cancellation moves it left. The exponent is corrected, low bits are dropped by truncation, and the fields are packed again. Rounding modes, subnormals, NaN/infinity and flags are not provided. The only special handling is zero detection, saturation on overflow and flush to zero on underflow. A parameter places a result register at the output, or leaves the path purely combinational.

Top module: `fpa_addsub`

## Requirements
- R1: A word is packed as {sign (MSB), exponent (`EXP_W` bits), fraction (`MAN_W` LSBs)}. Bias is 2^(EXP_W-1)-1 and the value is (-1)^s * 1.f * 2^(e-bias). An exponent field of 0 means zero, whatever the fraction holds.
- R2: `sub_sel`=0 yields a+b and `sub_sel`=1 yields a-b, computed by inverting b's sign before the shared adder.
- R3: When the exact result is zero (for example x-x), the output is all-zero (+0).
- R4: For in-range results the output is within one unit in the last place of the exact sum or difference. Discarded bits are truncated.
- R5: A significand sum of 2 or more increments the exponent by exactly one (1.5+1.5 gives exactly 3.0). The result exponent never exceeds the larger input exponent plus one.
- R6: Adding a zero operand returns the other operand bit-exactly. Subtracting from zero returns the other operand with its sign flipped.
- R7: The result sign is the sign of the operand with the larger magnitude, after the subtract inversion. Two nonzero operands of the same effective sign give that sign.
- R8: Cancellation is normalized by a left shift with exponent decrement (1.0-0.75 gives exactly 0.25).
- R9: If the result exponent would exceed 2^EXP_W-1, the output saturates to {sign, all-ones exponent, all-ones fraction}.
- R10: If the normalized exponent would be 0 or below, the output is all-zero. An output with a zero exponent field is always entirely zero.
- R11: With `REG_OUT`=1 the result appears one clock after the operands and reset clears it to zero. With `REG_OUT`=0 the result follows the operands without a clock.
- R12: The same RTL works for the (8,7), (8,15) and (8,23) layouts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Active-low asynchronous reset of the result register |
| op_a | input | EXP_W+MAN_W+1 | First operand, packed |
| op_b | input | EXP_W+MAN_W+1 | Second operand, packed |
| sub_sel | input | 1 | 0 = add, 1 = subtract b from a |
| result | output | EXP_W+MAN_W+1 | Packed sum or difference |

## Verification
On every clock, assertions check the relations that hold for any operands. Self-subtraction must give zero. A zero second operand must pass the first through unchanged. Like-signed operands must keep their sign. The exponent may grow by at most one. An output with a zero exponent field must be zero throughout. The numerical accuracy bound, the exact carry and cancellation cases, saturation and flush boundaries, zero-exponent inputs with stray fraction bits, and the timing difference between the registered and combinational variants can only be shown by the bench. It runs directed and random operands against a real-valued model in all three layouts.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   typedef enum logic {
      FPA_ADD = 1'b0,
      FPA_SUB = 1'b1
   } fpa_op_e;

   function automatic int fpa_imax(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
   import fpa_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 7
) (
   input  logic [EXP_W+MAN_W:0] word_i,
   input  logic                 negate_i,
   output logic                 sgn_o,
   output logic [EXP_W-1:0]     exp_o,
   output logic [MAN_W:0]       sig_o
);
   localparam int W = EXP_W + MAN_W + 1;

   logic raw_sgn;

   assign raw_sgn = word_i[W-1];
   assign exp_o   = word_i[W-2:MAN_W];

   // sign inversion through a selectable NOT for the subtract path
   always_comb begin
      if (fpa_op_e'(negate_i) == FPA_SUB) sgn_o = ~raw_sgn;
      else                                sgn_o = raw_sgn;
   end

   // hidden one restored only for a nonzero exponent; zero exponent is zero
   assign sig_o = (exp_o != '0) ? {1'b1, word_i[MAN_W-1:0]} : '0;

endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 7
) (
   input  logic                 sgn_a,
   input  logic [EXP_W-1:0]     exp_a,
   input  logic [MAN_W:0]       sig_a,
   input  logic                 sgn_b,
   input  logic [EXP_W-1:0]     exp_b,
   input  logic [MAN_W:0]       sig_b,
   output logic                 sgn_r,
   output logic [EXP_W-1:0]     exp_r,
   output logic [2*MAN_W+2:0]   sum_r
);
   localparam int SIGW = MAN_W + 1;
   localparam int AW   = 2 * SIGW;
   localparam int SUMW = AW + 1;

   logic             a_big;
   logic             big_s, sml_s;
   logic [EXP_W-1:0] big_e, sml_e, gap;
   logic [SIGW-1:0]  big_m, sml_m;
   logic [AW-1:0]    big_al, sml_al;

   // magnitude order: exponent first, significand second
   assign a_big = {exp_a, sig_a} >= {exp_b, sig_b};

   always_comb begin
      if (a_big) begin
         big_s = sgn_a; big_e = exp_a; big_m = sig_a;
         sml_s = sgn_b; sml_e = exp_b; sml_m = sig_b;
      end else begin
         big_s = sgn_b; big_e = exp_b; big_m = sig_b;
         sml_s = sgn_a; sml_e = exp_a; sml_m = sig_a;
      end
      gap    = big_e - sml_e;
      big_al = {big_m, {SIGW{1'b0}}};
      sml_al = {sml_m, {SIGW{1'b0}}} >> gap;
      if (big_s == sml_s) sum_r = {1'b0, big_al} + {1'b0, sml_al};
      else                sum_r = {1'b0, big_al} - {1'b0, sml_al};
   end

   assign sgn_r = big_s;
   assign exp_r = big_e;

   if (SUMW != 2*MAN_W+3) begin : g_bad_sum
      $error("fpa_align: sum width mismatch");
   end

endmodule

// File: rtl/fpa_lzc.sv
module fpa_lzc #(
   parameter int VEC_W = 17,
   parameter int CNT_W = $clog2(VEC_W + 1)
) (
   input  logic [VEC_W-1:0] vec_i,
   output logic [CNT_W-1:0] zeros_o,
   output logic             empty_o
);
   logic hit;

   always_comb begin
      zeros_o = '0;
      hit     = 1'b0;
      for (int i = VEC_W - 1; i >= 0; i--) begin
         if (vec_i[i])  hit     = 1'b1;
         else if (!hit) zeros_o = zeros_o + CNT_W'(1);
      end
   end

   assign empty_o = (vec_i == '0);

   if (VEC_W < 2) begin : g_bad_vec
      $error("fpa_lzc: vector too narrow");
   end

endmodule

// File: rtl/fpa_normpack.sv
module fpa_normpack
   import fpa_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 7
) (
   input  logic                 sgn_r,
   input  logic [EXP_W-1:0]     exp_r,
   input  logic [2*MAN_W+2:0]   sum_r,
   output logic [EXP_W+MAN_W:0] word_o
);
   localparam int SUMW = 2 * MAN_W + 3;
   localparam int CW   = $clog2(SUMW + 1);
   localparam int XW   = fpa_imax(EXP_W, CW) + 2;
   localparam logic [XW-1:0] EMAX = XW'((1 << EXP_W) - 1);

   logic [CW-1:0]    lz;
   logic             is_zero;
   logic [SUMW-1:0]  shifted;
   logic [MAN_W-1:0] frac;
   logic [XW-1:0]    e_plus, e_res;
   logic             unused_bits;

   fpa_lzc #(.VEC_W(SUMW), .CNT_W(CW)) u_lzc (
      .vec_i   (sum_r),
      .zeros_o (lz),
      .empty_o (is_zero)
   );

   // carry (lz=0) acts as a right shift by one; lz>1 is a left shift
   assign shifted     = sum_r << lz;
   assign frac        = shifted[SUMW-2 -: MAN_W];
   assign unused_bits = ^{shifted[SUMW-1], shifted[SUMW-MAN_W-2:0]};

   // exponent of the leading one: exp_r + 1 - lz, kept unsigned
   assign e_plus = XW'(exp_r) + XW'(1);
   assign e_res  = e_plus - XW'(lz);

   always_comb begin
      if (is_zero || (XW'(lz) >= e_plus))
         word_o = '0;
      else if (e_res > EMAX)
         word_o = {sgn_r, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
      else
         word_o = {sgn_r, e_res[EXP_W-1:0], frac};
   end

endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub
   import fpa_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 7,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EXP_W+MAN_W:0] op_a,
   input  logic [EXP_W+MAN_W:0] op_b,
   input  logic                 sub_sel,
   output logic [EXP_W+MAN_W:0] result
);
   localparam int W    = EXP_W + MAN_W + 1;
   localparam int SUMW = 2 * MAN_W + 3;
   localparam int XW   = EXP_W + 2;

   if (EXP_W < 2 || EXP_W > 15) begin : g_bad_exp
      $error("fpa_addsub: EXP_W out of range");
   end
   if (MAN_W < 1 || MAN_W > 30) begin : g_bad_man
      $error("fpa_addsub: MAN_W out of range");
   end

   logic             a_s, b_s, r_s;
   logic [EXP_W-1:0] a_e, b_e, r_e;
   logic [MAN_W:0]   a_m, b_m;
   logic [SUMW-1:0]  r_sum;
   logic [W-1:0]     packed_res;

   fpa_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_a (
      .word_i (op_a), .negate_i (1'b0),
      .sgn_o (a_s), .exp_o (a_e), .sig_o (a_m)
   );

   fpa_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_b (
      .word_i (op_b), .negate_i (sub_sel),
      .sgn_o (b_s), .exp_o (b_e), .sig_o (b_m)
   );

   fpa_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
      .sgn_a (a_s), .exp_a (a_e), .sig_a (a_m),
      .sgn_b (b_s), .exp_b (b_e), .sig_b (b_m),
      .sgn_r (r_s), .exp_r (r_e), .sum_r (r_sum)
   );

   fpa_normpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pack (
      .sgn_r (r_s), .exp_r (r_e), .sum_r (r_sum),
      .word_o (packed_res)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) result <= '0;
         else        result <= packed_res;
      end

      logic [XW-1:0] exp_hi;
      assign exp_hi = ((a_e > b_e) ? XW'(a_e) : XW'(b_e)) + XW'(1);

      a_r3_cancel_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (sub_sel && (op_a == op_b)) |=> (result == '0));

      a_r6_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
         ((b_e == '0) && (a_e != '0)) |=> (result == $past(op_a)));

      a_r7_like_sign: assert property (@(posedge clk) disable iff (!rst_n)
         ((a_e != '0) && (b_e != '0) && (op_a[W-1] == (op_b[W-1] ^ sub_sel)))
         |=> (result[W-1] == $past(op_a[W-1])));

      a_r5_exp_bound: assert property (@(posedge clk) disable iff (!rst_n)
         (a_e != '0) |=> (XW'(result[W-2:MAN_W]) <= $past(exp_hi)));

      a_r10_zero_canonical: assert property (@(posedge clk) disable iff (!rst_n)
         (result[W-2:MAN_W] == '0) |-> (result == '0));
   end else begin : g_comb
      assign result = packed_res;
   end

endmodule

// File: tb/tb_fpa_addsub.sv
module tb_fpa_addsub;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [15:0] a16 = '0, b16 = '0, r16;
   logic [23:0] a24 = '0, b24 = '0, r24;
   logic [31:0] a32 = '0, b32 = '0, r32;
   logic        sub = 1'b0;
   int total = 0;
   int bad   = 0;

   // R12: three layouts from one RTL; the 24-bit one uses the combinational variant
   fpa_addsub #(.EXP_W(8), .MAN_W(7)) dut (
      .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .sub_sel(sub), .result(r16));
   fpa_addsub #(.EXP_W(8), .MAN_W(15), .REG_OUT(1'b0)) dut24 (
      .clk(clk), .rst_n(rst_n), .op_a(a24), .op_b(b24), .sub_sel(sub), .result(r24));
   fpa_addsub #(.EXP_W(8), .MAN_W(23)) dut32 (
      .clk(clk), .rst_n(rst_n), .op_a(a32), .op_b(b32), .sub_sel(sub), .result(r32));

   localparam int EB = 8;
   localparam int BIAS = 127;

   function automatic logic [63:0] mk(bit s, int eu, real frac, int m);
      logic [63:0] ex, man;
      ex  = 64'(eu + BIAS) & 64'hFF;
      man = 64'(longint'($floor(frac * $pow(2.0, m))));
      return (64'(s) << (EB + m)) | (ex << m) | man;
   endfunction

   function automatic real to_real(logic [63:0] w, int m);
      longint ex, man;
      real v;
      ex  = longint'((w >> m) & 64'hFF);
      man = longint'(w & ((64'd1 << m) - 64'd1));
      if (ex == 0) return 0.0;
      v = (1.0 + real'(man) / $pow(2.0, m)) * $pow(2.0, real'(ex - BIAS));
      return w[EB + m] ? -v : v;
   endfunction

   function automatic int flog2(real x);
      int k = 0;
      real y = x;
      while (y >= 2.0) begin y = y / 2.0; k++; end
      while (y < 1.0)  begin y = y * 2.0; k--; end
      return k;
   endfunction

   task automatic chkbits(string req, string fmt, logic [63:0] got, logic [63:0] exp_w);
      total++;
      if (got !== exp_w) begin
         bad++;
         $display("FAIL %s fmt=%s actual=%h expected=%h", req, fmt, got, exp_w);
      end
   endtask

   // reference: exact real result, then saturate / flush / one-ULP window
   task automatic chk(string req, string fmt, logic [63:0] got, logic [63:0] a,
                      logic [63:0] b, bit s, int m);
      real ra, rb, ex, g, mag, ulp;
      int lg;
      ra = to_real(a, m);
      rb = to_real(b, m);
      ex = s ? ra - rb : ra + rb;
      g  = to_real(got, m);
      if (ex == 0.0) begin
         chkbits(req, fmt, got, 64'd0);
      end else begin
         mag = (ex < 0.0) ? -ex : ex;
         lg  = flog2(mag);
         if (lg + BIAS >= 256)
            chkbits(req, fmt, got, (64'(ex < 0.0) << (EB + m)) | ((64'd1 << (EB + m)) - 64'd1));
         else if (lg + BIAS <= 0)
            chkbits(req, fmt, got, 64'd0);
         else begin
            total++;
            ulp = $pow(2.0, real'(lg - m)) * 1.0001;
            if (((g - ex) > ulp) || ((ex - g) > ulp)) begin
               bad++;
               $display("FAIL %s fmt=%s actual=%h (%g) expected=%g", req, fmt, got, g, ex);
            end
         end
      end
   endtask

   task automatic step(string req, bit s, bit sa, int ea, real fa, bit sb, int eb, real fb);
      @(negedge clk);
      a16 = 16'(mk(sa, ea, fa, 7));  b16 = 16'(mk(sb, eb, fb, 7));
      a24 = 24'(mk(sa, ea, fa, 15)); b24 = 24'(mk(sb, eb, fb, 15));
      a32 = 32'(mk(sa, ea, fa, 23)); b32 = 32'(mk(sb, eb, fb, 23));
      sub = s;
      @(negedge clk);
      chk(req, "16", 64'(r16), 64'(a16), 64'(b16), s, 7);
      chk(req, "24", 64'(r24), 64'(a24), 64'(b24), s, 15);
      chk(req, "32", 64'(r32), 64'(a32), 64'(b32), s, 23);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chkbits("R11 reset", "16", 64'(r16), 64'd0);
      chkbits("R11 reset", "32", 64'(r32), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: registered output waits for the edge, combinational does not
      a16 = 16'(mk(0, 0, 0.0, 7));  b16 = a16;
      a24 = 24'(mk(0, 0, 0.0, 15)); b24 = a24;
      sub = 1'b0;
      #1;
      chkbits("R11 latency", "16", 64'(r16), 64'd0);
      chkbits("R11 comb", "24", 64'(r24), mk(0, 1, 0.0, 15));
      @(negedge clk);
      chkbits("R11 latency", "16", 64'(r16), mk(0, 1, 0.0, 7));

      step("R5 carry", 0, 0, 0, 0.5, 0, 0, 0.5);
      chkbits("R5 carry exact", "16", 64'(r16), mk(0, 1, 0.5, 7));
      chkbits("R5 carry exact", "32", 64'(r32), mk(0, 1, 0.5, 23));
      step("R2 sub of negative", 1, 0, 1, 0.25, 1, 0, 0.0);
      chkbits("R2 exact", "16", 64'(r16), mk(0, 1, 0.75, 7));
      step("R2 add mixed sign", 0, 0, 1, 0.25, 1, 0, 0.0);
      step("R7 sign of larger", 1, 0, 0, 0.0, 0, 2, 0.0);
      chkbits("R7 exact", "16", 64'(r16), mk(1, 1, 0.5, 7));
      step("R3 self cancel", 1, 1, 5, 0.375, 1, 5, 0.375);
      step("R8 left normalize", 1, 0, 0, 0.0, 0, -1, 0.5);
      chkbits("R8 exact", "32", 64'(r32), mk(0, -2, 0.0, 23));
      step("R6 plus zero", 0, 0, 3, 0.75, 0, -127, 0.0);
      chkbits("R6 exact", "16", 64'(r16), 64'(a16));
      chkbits("R6 exact", "24", 64'(r24), 64'(a24));
      step("R6 zero minus", 1, 0, -127, 0.0, 0, 3, 0.75);
      chkbits("R6 exact flip", "32", 64'(r32), mk(1, 3, 0.75, 23));
      step("R1 zero exponent stray fraction", 0, 0, 2, 0.25, 0, -127, 0.5);
      chkbits("R1 exact", "16", 64'(r16), 64'(a16));
      step("R9 saturate", 0, 0, 128, 0.5, 0, 128, 0.5);
      step("R9 saturate negative", 1, 1, 128, 0.5, 0, 128, 0.5);
      step("R9 near top no saturate", 0, 0, 128, 0.25, 0, 120, 0.25);
      step("R10 flush", 1, 0, -126, 0.5, 0, -126, 0.25);
      step("R10 both zero", 0, 0, -127, 0.0, 1, -127, 0.0);

      for (int i = 0; i < 250; i++) begin
         step("R4 random", 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), $urandom_range(0, 40) - 20,
              real'($urandom) / 4294967296.0,
              1'($urandom_range(0, 1)), $urandom_range(0, 40) - 20,
              real'($urandom) / 4294967296.0);
      end
      for (int i = 0; i < 60; i++) begin
         step("R8 random near cancel", 1, 0, 4, 0.5 + real'($urandom_range(0, 255)) / 1024.0,
              0, 4, 0.5 + real'($urandom_range(0, 255)) / 1024.0);
      end

      summary();
      $finish;
   end
endmodule